// File: doc/BRIEF.md
# Lock-Bit Set Host Sequencer

This block sits on the host side of a byte-wide flash bus. It drives the command writes that set one or more block protection bits, or the single device-wide protection bit, in a flash device. After a start request it issues a setup and a confirm write for each target. It then polls the device status byte until the ready bit comes up and decodes the error bits in a fixed priority. When an error is found it clears the device status. It always finishes by returning the device to array-read mode. A single registered result code and a one-cycle done pulse report the outcome.

Blocks are addressed from a base address plus a fixed block stride per operation. The device-wide bit is always written at one fixed device address. The caller chooses whether the status check runs after every operation, which stops at the first failing one, or only once after the whole batch. In the batch case the device's sticky error bits still expose an error from any earlier operation. The bus carries one access per cycle. Read data is sampled in the same cycle as the read strobe.

Top module: `lockset_seq`

## Requirements
- R1: For block k of a batch (k = 0..n-1), the block writes data 60h and then, in the next cycle, data 01h, both at address base_i + k * 2^BLK_SHIFT.
- R2: With master_i = 1, exactly one operation is done, whatever count_i is. Its second write carries data F1h, and both writes go to address DEV_ADDR (default 0).
- R3: After each confirm write, status is read every cycle until bit 7 of bus_rdata_i is 1. No further write is issued while that bit is 0, unless the poll times out.
- R4: The status byte is decoded by priority. Bit 3 gives result 1 (supply voltage error). Otherwise bit 1 gives 2 (protected). Otherwise bits 4 and 5 both set give 3 (command sequence error). Otherwise bit 4 gives 4 (lock-set error). Otherwise the result is 0 (success).
- R5: Status bit 5 set without bit 4 counts as success.
- R6: With check_each_i = 1, status is decoded after every operation, and the batch stops at the first operation that shows an error.
- R7: With check_each_i = 0, status is decoded only once, after the last operation. Sticky error bits from an earlier operation are reported.
- R8: When the result is 1 to 4, a single write of 50h to DEV_ADDR precedes the final restore write. It is never issued on success or on timeout.
- R9: The last write of every run is FFh to DEV_ADDR. done_o pulses high for one cycle right after it, and result_o is updated at that same edge and held until the next done.
- R10: If TIMEOUT_CYC consecutive status reads (default 64) all show bit 7 at 0, the run ends with result 5. No further operation is issued, and no clear write is issued.
- R11: After reset, busy_o, done_o, both strobes and result_o are 0. A start_i pulse while busy_o is 1 is ignored.
- R12: count_i = 0 is treated as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (taken only when idle) |
| master_i | input | 1 | 1: device-wide bit, 0: block bits |
| check_each_i | input | 1 | 1: check status after every operation |
| count_i | input | CNT_W | Number of blocks |
| base_i | input | ADDR_W | Address of the first block |
| bus_rdata_i | input | 8 | Status byte from the device |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 3 | Result code of the last run |

## Verification
A behavioural flash model in the bench answers writes, holds sticky error bits and stays busy for a programmable number of cycles. It is driven with single and multi-block batches, the device-wide mode, and each error byte alone and in overlapping combinations such as 3Ah and 12h. These separate the priority order from a plain first-bit match. The same error is placed on a middle operation in both check modes. This tells early stop apart from batch-end reporting, and the full write log checks the clear and restore commands. A device that never becomes ready, a zero count, and a start pulse during a run cover the remaining corners.

// File: rtl/lockset_pkg.sv
package lockset_pkg;
  typedef enum logic [2:0] {
    RES_OK   = 3'd0,
    RES_VPP  = 3'd1,
    RES_PROT = 3'd2,
    RES_SEQ  = 3'd3,
    RES_LOCK = 3'd4,
    RES_TMO  = 3'd5
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CONFIRM, ST_POLL, ST_CHECK, ST_CLEAR, ST_ARRAY
  } st_e;

  localparam logic [7:0] CMD_SETUP = 8'h60;
  localparam logic [7:0] CMD_BLK   = 8'h01;
  localparam logic [7:0] CMD_MST   = 8'hF1;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;

  localparam int SR_RDY  = 7;
  localparam int SR_B5   = 5;
  localparam int SR_B4   = 4;
  localparam int SR_VPP  = 3;
  localparam int SR_PROT = 1;
endpackage

// File: rtl/lockset_decode.sv
module lockset_decode
  import lockset_pkg::*;
(
  input  logic [7:0] stat_i,
  output res_e       code_o,
  output logic       err_o
);
  always_comb begin
    if (stat_i[SR_VPP])                     code_o = RES_VPP;
    else if (stat_i[SR_PROT])               code_o = RES_PROT;
    else if (stat_i[SR_B5] && stat_i[SR_B4]) code_o = RES_SEQ;
    else if (stat_i[SR_B4])                 code_o = RES_LOCK;
    else                                    code_o = RES_OK;
  end
  assign err_o = (code_o != RES_OK);
endmodule

// File: rtl/lockset_addr.sv
module lockset_addr #(
  parameter int ADDR_W    = 20,
  parameter int CNT_W     = 4,
  parameter int BLK_SHIFT = 16,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              master_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [CNT_W-1:0]  idx_q, last_q;
  logic [ADDR_W-1:0] base_q;
  logic              mst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      last_q <= '0;
      base_q <= '0;
      mst_q  <= 1'b0;
    end else if (load_i) begin
      idx_q  <= '0;
      base_q <= base_i;
      mst_q  <= master_i;
      // master: single op; zero count acts as one
      last_q <= (master_i || count_i == '0) ? '0 : count_i - 1'b1;
    end else if (step_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign addr_o = mst_q ? DEV_ADDR : base_q + (ADDR_W'(idx_q) << BLK_SHIFT);
  assign last_o = (idx_q == last_q);
endmodule

// File: rtl/lockset_timer.sv
module lockset_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = tick_i && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/lockset_seq.sv
module lockset_seq
  import lockset_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CNT_W       = 4,
  parameter int BLK_SHIFT   = 16,
  parameter int TIMEOUT_CYC = 64,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              master_i,
  input  logic              check_each_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [7:0]        bus_rdata_i,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        result_o
);
  st_e  st_q, st_d;
  logic mst_q, each_q, done_q;
  logic [7:0] stat_q;
  res_e res_q, res_d, dec_code;
  logic [2:0] result_q;
  logic dec_err;

  logic load, step, tick, tclr, expired, last;
  logic [ADDR_W-1:0] op_addr;

  lockset_addr #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_SHIFT(BLK_SHIFT), .DEV_ADDR(DEV_ADDR)
  ) i_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .master_i(master_i), .count_i(count_i), .base_i(base_i),
    .addr_o(op_addr), .last_o(last)
  );

  lockset_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tclr), .tick_i(tick),
    .expired_o(expired)
  );

  lockset_decode i_dec (.stat_i(stat_q), .code_o(dec_code), .err_o(dec_err));

  wire rdy = bus_rdata_i[SR_RDY];

  always_comb begin
    st_d        = st_q;
    res_d       = res_q;
    load        = 1'b0;
    step        = 1'b0;
    tick        = 1'b0;
    tclr        = 1'b0;
    bus_we_o    = 1'b0;
    bus_re_o    = 1'b0;
    bus_addr_o  = op_addr;
    bus_wdata_o = 8'h00;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load  = 1'b1;
        res_d = RES_OK;
        st_d  = ST_SETUP;
      end
      ST_SETUP: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_SETUP;
        st_d        = ST_CONFIRM;
      end
      ST_CONFIRM: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = mst_q ? CMD_MST : CMD_BLK;
        tclr        = 1'b1;
        st_d        = ST_POLL;
      end
      ST_POLL: begin
        bus_re_o = 1'b1;
        if (rdy) begin
          if (each_q || last) st_d = ST_CHECK;
          else begin
            step = 1'b1;
            st_d = ST_SETUP;
          end
        end else begin
          tick = 1'b1;
          if (expired) begin
            res_d = RES_TMO;
            st_d  = ST_ARRAY;
          end
        end
      end
      ST_CHECK: begin
        if (dec_err) begin
          res_d = dec_code;
          st_d  = ST_CLEAR;
        end else if (last) begin
          st_d = ST_ARRAY;
        end else begin
          step = 1'b1;
          st_d = ST_SETUP;
        end
      end
      ST_CLEAR: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_CLR;
        bus_addr_o  = DEV_ADDR;
        st_d        = ST_ARRAY;
      end
      ST_ARRAY: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_ARRAY;
        bus_addr_o  = DEV_ADDR;
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mst_q    <= 1'b0;
      each_q   <= 1'b0;
      stat_q   <= '0;
      res_q    <= RES_OK;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      st_q   <= st_d;
      res_q  <= res_d;
      done_q <= (st_q == ST_ARRAY);
      if (load) begin
        mst_q  <= master_i;
        each_q <= check_each_i;
      end
      if (st_q == ST_POLL && rdy) stat_q <= bus_rdata_i;
      if (st_q == ST_ARRAY) result_q <= res_q;
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/lockset_chk.sv
module lockset_chk #(
  parameter int ADDR_W      = 20,
  parameter int CNT_W       = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              master_i,
  input logic              check_each_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [7:0]        bus_rdata_i,
  input logic              bus_we_o,
  input logic              bus_re_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [7:0]        bus_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [2:0]        result_o
);
  int nr_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nr_cnt <= 0;
    else if (bus_re_o && !bus_rdata_i[7]) nr_cnt <= nr_cnt + 1;
    else nr_cnt <= 0;
  end

  a_r1_setup_then_confirm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_wdata_o == 8'h60) |=>
      (bus_we_o && (bus_wdata_o == 8'h01 || bus_wdata_o == 8'hF1) && $stable(bus_addr_o)));

  a_r3_confirm_then_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && (bus_wdata_o == 8'h01 || bus_wdata_o == 8'hF1)) |=> bus_re_o);

  a_r3_poll_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_o && !bus_rdata_i[7]) |=> (bus_re_o || (bus_we_o && bus_wdata_o == 8'hFF)));

  a_r3_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  a_r8_clear_then_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_wdata_o == 8'h50) |=> (bus_we_o && bus_wdata_o == 8'hFF));

  a_r9_done_after_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_we_o && bus_wdata_o == 8'hFF));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r10_poll_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nr_cnt <= TIMEOUT_CYC);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_we_o && !bus_re_o));
endmodule

bind lockset_seq lockset_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) i_chk (.*);

// File: tb/test_lockset_seq.sv
`timescale 1ns/1ps
module test_lockset_seq;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 4;
  localparam logic [ADDR_W-1:0] BASE = 20'h30000;

  typedef struct packed {
    logic       mst;
    logic [3:0] cnt;
    logic       each;
    logic [7:0] lat;
    logic [3:0] err_op;
    logic [7:0] err_bits;
    logic [2:0] res;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd3, 1'b1, 8'd2,   4'hF, 8'h00, 3'd0},
    '{1'b1, 4'd4, 1'b1, 8'd3,   4'hF, 8'h00, 3'd0},
    '{1'b0, 4'd2, 1'b1, 8'd1,   4'd0, 8'h08, 3'd1},
    '{1'b0, 4'd3, 1'b1, 8'd2,   4'd1, 8'h02, 3'd2},
    '{1'b0, 4'd3, 1'b1, 8'd2,   4'd1, 8'h30, 3'd3},
    '{1'b0, 4'd2, 1'b1, 8'd0,   4'd0, 8'h10, 3'd4},
    '{1'b0, 4'd3, 1'b0, 8'd2,   4'd0, 8'h10, 3'd4},
    '{1'b0, 4'd2, 1'b1, 8'd1,   4'd0, 8'h3A, 3'd1},
    '{1'b0, 4'd2, 1'b1, 8'd1,   4'd0, 8'h12, 3'd2},
    '{1'b0, 4'd2, 1'b1, 8'd1,   4'd0, 8'h20, 3'd0},
    '{1'b0, 4'd0, 1'b1, 8'd0,   4'hF, 8'h00, 3'd0},
    '{1'b1, 4'd1, 1'b0, 8'd100, 4'hF, 8'h00, 3'd5},
    '{1'b0, 4'd4, 1'b0, 8'd1,   4'd2, 8'h30, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, master = 1'b0, each = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic [ADDR_W-1:0] base = '0;
  logic [7:0] rdata;
  logic we, re, busy, done;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata;
  logic [2:0] result;

  always #2.5 clk = ~clk;

  lockset_seq i_lockset_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .master_i(master),
    .check_each_i(each), .count_i(count), .base_i(base), .bus_rdata_i(rdata),
    .bus_we_o(we), .bus_re_o(re), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  // flash device model
  logic       mdl_clr = 1'b0;
  logic [7:0] cfg_lat = '0, cfg_bits = '0;
  logic [3:0] cfg_op = 4'hF;
  logic [7:0] sr;
  int         busy_cnt, op_num, wr_n, viol;
  logic       armed;
  logic [ADDR_W-1:0] log_a [64];
  logic [7:0]        log_d [64];

  assign rdata = (busy_cnt != 0) ? 8'h00 : (8'h80 | sr);

  always @(posedge clk) begin
    if (mdl_clr) begin
      sr <= '0; busy_cnt <= 0; op_num <= 0; wr_n <= 0; viol <= 0; armed <= 1'b0;
    end else begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (we) begin
        if (wr_n < 64) begin
          log_a[wr_n] <= addr;
          log_d[wr_n] <= wdata;
        end
        wr_n <= wr_n + 1;
        if (busy_cnt > 0) viol <= viol + 1;
        armed <= 1'b0;
        if (wdata == 8'h60) armed <= 1'b1;
        else if ((wdata == 8'h01 || wdata == 8'hF1) && armed) begin
          busy_cnt <= int'(cfg_lat);
          if (op_num == int'(cfg_op)) sr <= sr | cfg_bits;
          op_num <= op_num + 1;
        end else if (wdata == 8'h50) sr <= '0;
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model_reset(input vec_t v);
    @(negedge clk);
    cfg_lat = v.lat; cfg_bits = v.err_bits; cfg_op = v.err_op;
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 2000) begin
        ok = 1'b0;
        break;
      end
    end
  endtask

  task automatic check_seq(input vec_t v, input int idx);
    logic [ADDR_W-1:0] ea [64];
    logic [7:0]        ed [64];
    int en = 0, ops, n;
    bit err = (v.res >= 3'd1 && v.res <= 3'd4);
    n = v.mst ? 1 : ((v.cnt == 0) ? 1 : int'(v.cnt));
    if (v.res == 3'd5) ops = 1;
    else if (v.each && v.res != 3'd0) ops = int'(v.err_op) + 1;
    else ops = n;
    for (int k = 0; k < ops; k++) begin
      ea[en] = v.mst ? '0 : BASE + (ADDR_W'(k) << 16);
      ed[en] = 8'h60; en++;
      ea[en] = ea[en-1];
      ed[en] = v.mst ? 8'hF1 : 8'h01; en++;
    end
    if (err) begin ea[en] = '0; ed[en] = 8'h50; en++; end
    ea[en] = '0; ed[en] = 8'hFF; en++;
    chk(wr_n == en, $sformatf("R1 R2 R6 R7 R8 R10 R12 vec %0d write count", idx), wr_n, en);
    if (wr_n == en) begin
      bit same = 1'b1;
      int bad = 0;
      for (int i = 0; i < en; i++)
        if (log_a[i] !== ea[i] || log_d[i] !== ed[i]) begin
          if (same) bad = i;
          same = 1'b0;
        end
      chk(same, $sformatf("R1 R2 R8 R9 vec %0d write %0d addr/data", idx, bad),
          int'({log_a[bad], log_d[bad]}), int'({ea[bad], ed[bad]}));
    end
    if (v.res != 3'd5)
      chk(viol == 0, $sformatf("R3 vec %0d write while device busy", idx), viol, 0);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    bit ok;
    model_reset(v);
    master = v.mst; each = v.each; count = v.cnt; base = BASE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok, $sformatf("R9 vec %0d done seen", idx), ok, 1);
    chk(result == v.res, $sformatf("R4 R5 R6 R7 R10 vec %0d result", idx), result, v.res);
    check_seq(v, idx);
    @(negedge clk);
    chk(!done && !busy, $sformatf("R9 vec %0d done one cycle", idx), {done, busy}, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !we && !re && result == 3'd0, "R11 reset state",
        {busy, done, we, re, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R11: start while busy is ignored
    begin
      bit ok;
      vec_t v = '{1'b0, 4'd2, 1'b1, 8'd3, 4'hF, 8'h00, 3'd0};
      model_reset(v);
      master = 1'b0; each = 1'b1; count = 4'd2; base = BASE;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      master = 1'b1; count = 4'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk(ok && result == 3'd0, "R11 run with extra start result", result, 0);
      check_seq(v, 99);
      repeat (20) @(negedge clk);
      chk(!busy && !done, "R11 no second run after ignored start", {busy, done}, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule